// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the memory-mapped register side of a serial port. It sits on a single-cycle register bus inside a 4 KiB address window. Bytes that arrive from a receive path enter a small queue. A processor takes them out by reading the data register. A write to the same data register sends its low byte out on a transmit strobe.

Around the data path the block holds the flag word and the interrupt logic. The interrupt logic has raw status, a mask, a masked view and a write-one-to-clear register, and it drives a single level interrupt line. The block also holds seven plain configuration registers, which are stored and read back and do nothing else, and eight fixed identification words at the top of the window. The bit shifter, the baud generator, the modem lines and DMA are not part of this block.

A bus read is sampled on one clock edge, and its data appears on `bus_rdata` after that same edge. `bus_rdata` holds its value until the next read.

Top module: `serial_regfile`

## Requirements
- R1: Reset values. After reset the flag word (offset 0x18) reads 0x90, which is transmit-empty at bit 7 and receive-empty at bit 4. Raw status, mask, receive status and every configuration register read 0, and `irq` is low.
- R2: Data read. A read of offset 0x00 returns the oldest queued byte in bits 7:0 and removes it from the queue. When the queue is empty it returns 0. The read data appears after the clock edge that samples the read.
- R3: Receive push. Each `rx_valid` cycle sets raw bit 4 (receive) and appends `rx_byte` to the queue if there is room. The flag word then has bit 4 (receive-empty) clear.
- R4: Last-byte read. A data read that empties the queue sets flag bit 4 and clears raw bit 4. If a byte is pushed in the same cycle, the queue is not empty and raw bit 4 stays set.
- R5: Full queue. The queue holds FIFO_DEPTH bytes (16 by default). Flag bit 6 (receive-full) is set while it is full. A push in the same cycle as a data read of a full queue is accepted.
- R6: Overrun. A push to a full queue with no data read in that cycle is dropped. It sets raw bit 10 and bit 3 of receive status (offset 0x04). Any write to offset 0x04 zeroes receive status, but an overrun in the same cycle wins.
- R7: Transmit. A write to offset 0x00 makes `tx_valid` high for exactly one cycle after the write edge, with `tx_byte` equal to write data bits 7:0. It also sets raw bit 5 (transmit). Flag bit 7 stays set.
- R8: Interrupt. The mask register (offset 0x38) keeps write data bits 10:0. Offset 0x40 reads raw (offset 0x3C) AND mask. `irq` is high whenever that AND is nonzero.
- R9: Clear. A write to offset 0x44 clears every raw bit whose write data bit is one. A status event in the same cycle wins over the clear.
- R10: Configuration storage. Each register keeps the low bits of the write data and reads back zero-extended:
  - 0x20 keeps 8 bits
  - 0x24 keeps 16 bits
  - 0x28 keeps 6 bits
  - 0x2C keeps 8 bits
  - 0x30 keeps 16 bits
  - 0x34 keeps 6 bits
  - 0x48 keeps 3 bits
- R11: Identification. Offsets 0xFE0, 0xFE4, 0xFE8 and 0xFEC read 0x11, 0x10, 0x14 and 0x00. Offsets 0xFF0, 0xFF4, 0xFF8 and 0xFFC read 0x0D, 0xF0, 0x05 and 0xB1.
- R12: Unmapped access. Reads of the clear register (0x44) or of unmapped offsets return 0. Writes to the flag, raw or masked offsets, or to unmapped offsets, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte offset within the window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | One-cycle strobe for a transmitted byte |
| tx_byte | output | 8 | Transmitted byte |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets several corner cases:
- It pops the last byte while a new byte arrives in the same cycle. A design that checks only the old count would drop the receive interrupt even though the queue is not empty.
- It fills the queue and then pushes with and without a simultaneous read. A design with the wrong full rule would lose a byte or would fail to flag an overrun.
- It clears a raw bit in the same cycle that the bit is set again. It writes to read-only and unmapped offsets.

A design that let the clear win, or that decoded those read-only or unmapped offsets loosely, would lose an event or corrupt state. A reference model compares `irq`, the transmit strobe and every read result on every cycle.

// File: rtl/sregs_pkg.sv
package sregs_pkg;
  localparam int OFS_W = 12;
  typedef logic [OFS_W-1:0] ofs_t;

  localparam ofs_t A_DATA  = 12'h000;
  localparam ofs_t A_RSR   = 12'h004;
  localparam ofs_t A_FLAG  = 12'h018;
  localparam ofs_t A_LPC   = 12'h020;
  localparam ofs_t A_IBAUD = 12'h024;
  localparam ofs_t A_FBAUD = 12'h028;
  localparam ofs_t A_LINE  = 12'h02C;
  localparam ofs_t A_CTRL  = 12'h030;
  localparam ofs_t A_LEVEL = 12'h034;
  localparam ofs_t A_MASK  = 12'h038;
  localparam ofs_t A_RAW   = 12'h03C;
  localparam ofs_t A_MSKD  = 12'h040;
  localparam ofs_t A_CLR   = 12'h044;
  localparam ofs_t A_DMA   = 12'h048;

  localparam int N_IRQ   = 11;
  localparam int IRQ_OVR = 10;
  localparam int IRQ_TX  = 5;
  localparam int IRQ_RX  = 4;

  localparam int FL_TXE = 7;
  localparam int FL_RXF = 6;
  localparam int FL_RXE = 4;

  localparam int RSR_W   = 4;
  localparam int RSR_OVR = 3;

  localparam int N_STORE = 7;
  localparam int STORE_W = 16;

  function automatic ofs_t store_ofs(int i);
    case (i)
      0: return A_LPC;
      1: return A_IBAUD;
      2: return A_FBAUD;
      3: return A_LINE;
      4: return A_CTRL;
      5: return A_LEVEL;
      default: return A_DMA;
    endcase
  endfunction

  function automatic int store_width(int i);
    case (i)
      0: return 8;
      1: return 16;
      2: return 6;
      3: return 8;
      4: return 16;
      5: return 6;
      default: return 3;
    endcase
  endfunction

  function automatic logic [7:0] id_byte(logic [2:0] k);
    case (k)
      3'd0: return 8'h11;
      3'd1: return 8'h10;
      3'd2: return 8'h14;
      3'd3: return 8'h00;
      3'd4: return 8'h0D;
      3'd5: return 8'hF0;
      3'd6: return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          accept
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          pop_ok;

  function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign pop_ok = pop && !empty;
  assign accept = push && (!full || pop_ok);
  assign dout   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (accept) wr_ptr <= nxt(wr_ptr);
      if (pop_ok) rd_ptr <= nxt(rd_ptr);
      case ({accept, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  p_drop_when_full_r6: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> (count == $past(count)));

  p_swap_when_full_r5: assert property (@(posedge clk) disable iff (rst)
    (push && full && pop) |=> full);
endmodule

// File: rtl/irq_status.sv
module irq_status #(
  parameter int N = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  input  logic         mask_we,
  input  logic [N-1:0] mask_din,
  output logic [N-1:0] raw,
  output logic [N-1:0] mask,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      raw  <= '0;
      mask <= '0;
    end else begin
      raw <= (raw & ~clr_vec) | set_vec;
      if (mask_we) mask <= mask_din;
    end
  end

  assign irq = |(raw & mask);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((raw & $past(set_vec)) == $past(set_vec)));

  p_clear_takes_r9: assert property (@(posedge clk) disable iff (rst)
    ((clr_vec & ~set_vec) != '0) |=> ((raw & $past(clr_vec & ~set_vec)) == '0));
endmodule

// File: rtl/serial_regfile.sv
module serial_regfile
  import sregs_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [11:0] bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  input  logic        bus_rd,
  output logic [31:0] bus_rdata,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  output logic        tx_valid,
  output logic [7:0]  tx_byte,
  output logic        irq
);
  logic [7:0]       q_head;
  logic [CW-1:0]    q_count;
  logic             q_full, q_empty, q_accept;
  logic             rd_data_hit, wr_data_hit, last_out, overrun;
  logic [N_IRQ-1:0] set_vec, clr_vec, raw, mask;
  logic [RSR_W-1:0] rsr;
  logic [N_STORE-1:0][STORE_W-1:0] store_vals;
  logic [31:0]      rd_val;
  logic [8:0]       flags;
  logic             unused_hi;

  assign unused_hi   = ^bus_wdata[31:STORE_W];
  assign rd_data_hit = bus_rd && (bus_addr == A_DATA);
  assign wr_data_hit = bus_wr && (bus_addr == A_DATA);
  assign last_out    = rd_data_hit && (q_count == CW'(1)) && !rx_valid;
  assign overrun     = rx_valid && !q_accept;

  rxq_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rxq (
    .clk(clk), .rst(rst),
    .push(rx_valid), .din(rx_byte), .pop(rd_data_hit),
    .dout(q_head), .count(q_count), .full(q_full), .empty(q_empty),
    .accept(q_accept)
  );

  always_comb begin
    set_vec = '0;
    set_vec[IRQ_RX]  = rx_valid;
    set_vec[IRQ_OVR] = overrun;
    set_vec[IRQ_TX]  = wr_data_hit;
    clr_vec = (bus_wr && bus_addr == A_CLR) ? bus_wdata[N_IRQ-1:0] : '0;
    if (last_out) clr_vec[IRQ_RX] = 1'b1;
  end

  irq_status #(.N(N_IRQ)) u_irq (
    .clk(clk), .rst(rst),
    .set_vec(set_vec), .clr_vec(clr_vec),
    .mask_we(bus_wr && bus_addr == A_MASK),
    .mask_din(bus_wdata[N_IRQ-1:0]),
    .raw(raw), .mask(mask), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) rsr <= '0;
    else begin
      rsr <= (bus_wr && bus_addr == A_RSR) ? '0 : rsr;
      if (overrun) rsr[RSR_OVR] <= 1'b1;
    end
  end

  for (genvar g = 0; g < N_STORE; g++) begin : g_store
    localparam int SW = store_width(g);
    localparam logic [STORE_W-1:0] KEEP = STORE_W'((32'd1 << SW) - 1);
    logic [STORE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else if (bus_wr && bus_addr == store_ofs(g)) q <= bus_wdata[STORE_W-1:0] & KEEP;
    end
    assign store_vals[g] = q;
  end

  // No transmit queue is kept, so transmit-empty stays asserted.
  always_comb begin
    flags = '0;
    flags[FL_TXE] = 1'b1;
    flags[FL_RXF] = q_full;
    flags[FL_RXE] = q_empty;
  end

  always_comb begin
    rd_val = '0;
    case (bus_addr)
      A_DATA:  rd_val = q_empty ? 32'd0 : {24'd0, q_head};
      A_RSR:   rd_val = 32'(rsr);
      A_FLAG:  rd_val = 32'(flags);
      A_MASK:  rd_val = 32'(mask);
      A_RAW:   rd_val = 32'(raw);
      A_MSKD:  rd_val = 32'(raw & mask);
      default: begin
        if (bus_addr[11:5] == 7'h7F && bus_addr[1:0] == 2'b00)
          rd_val = {24'd0, id_byte(bus_addr[4:2])};
        for (int i = 0; i < N_STORE; i++)
          if (bus_addr == store_ofs(i)) rd_val = 32'(store_vals[i]);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      tx_valid  <= 1'b0;
      tx_byte   <= '0;
    end else begin
      if (bus_rd) bus_rdata <= rd_val;
      tx_valid <= wr_data_hit;
      if (wr_data_hit) tx_byte <= bus_wdata[7:0];
    end
  end

  p_push_sets_rx_r3: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> (raw[IRQ_RX] && !q_empty));

  p_last_pop_r4: assert property (@(posedge clk) disable iff (rst)
    last_out |=> (!raw[IRQ_RX] && q_empty));

  p_overrun_r6: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && q_full && !rd_data_hit) |=> (rsr[RSR_OVR] && raw[IRQ_OVR]));

  p_tx_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    wr_data_hit |=> (tx_valid && raw[IRQ_TX]));

  p_tx_single_r7: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !$past(wr_data_hit)) |-> 1'b0);
endmodule

// File: tb/test_serial_regfile.sv
module test_serial_regfile;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, rx_valid = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [7:0]  rx_byte = '0;
  logic [31:0] bus_rdata;
  logic        tx_valid, irq;
  logic [7:0]  tx_byte;

  serial_regfile #(.FIFO_DEPTH(DEPTH)) i_serial_regfile (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_valid(tx_valid),
    .tx_byte(tx_byte), .irq(irq)
  );

  always #5 clk = ~clk;

  int    errors = 0, checks = 0;
  bit    done = 0;
  string cur_tag = "R1";

  // Reference model
  byte unsigned m_q[$];
  logic [10:0]  m_raw, m_mask;
  logic [3:0]   m_rsr;
  logic [15:0]  m_lpc, m_ib, m_fb, m_line, m_ctrl, m_lvl, m_dma;
  logic [31:0]  e_rdata;
  bit           e_rd, e_txv;
  logic [7:0]   e_txb;
  string        e_tag;
  bit           popped;

  function automatic logic [31:0] m_read(logic [11:0] a);
    case (a)
      12'h000: return (m_q.size() > 0) ? 32'(m_q[0]) : 32'd0;
      12'h004: return 32'(m_rsr);
      12'h018: return 32'h80 | ((m_q.size() == DEPTH) ? 32'h40 : 0) | ((m_q.size() == 0) ? 32'h10 : 0);
      12'h020: return 32'(m_lpc);
      12'h024: return 32'(m_ib);
      12'h028: return 32'(m_fb);
      12'h02C: return 32'(m_line);
      12'h030: return 32'(m_ctrl);
      12'h034: return 32'(m_lvl);
      12'h038: return 32'(m_mask);
      12'h03C: return 32'(m_raw);
      12'h040: return 32'(m_raw & m_mask);
      12'h048: return 32'(m_dma);
      12'hFE0: return 32'h11;
      12'hFE4: return 32'h10;
      12'hFE8: return 32'h14;
      12'hFEC: return 32'h00;
      12'hFF0: return 32'h0D;
      12'hFF4: return 32'hF0;
      12'hFF8: return 32'h05;
      12'hFFC: return 32'hB1;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_q.delete();
      m_raw = '0; m_mask = '0; m_rsr = '0;
      m_lpc = '0; m_ib = '0; m_fb = '0; m_line = '0; m_ctrl = '0; m_lvl = '0; m_dma = '0;
      e_rd = 0; e_txv = 0; e_rdata = '0; e_txb = '0;
    end else begin
      e_rd = bus_rd;
      e_tag = cur_tag;
      if (bus_rd) e_rdata = m_read(bus_addr);
      if (bus_wr && bus_addr == 12'h044) m_raw = m_raw & ~bus_wdata[10:0];
      popped = 0;
      if (bus_rd && bus_addr == 12'h000 && m_q.size() > 0) begin
        void'(m_q.pop_front());
        popped = 1;
        if (m_q.size() == 0) m_raw[4] = 1'b0;
      end
      e_txv = 0;
      if (bus_wr) begin
        case (bus_addr)
          12'h000: begin e_txv = 1; e_txb = bus_wdata[7:0]; m_raw[5] = 1'b1; end
          12'h004: m_rsr = '0;
          12'h020: m_lpc  = {8'd0, bus_wdata[7:0]};
          12'h024: m_ib   = bus_wdata[15:0];
          12'h028: m_fb   = {10'd0, bus_wdata[5:0]};
          12'h02C: m_line = {8'd0, bus_wdata[7:0]};
          12'h030: m_ctrl = bus_wdata[15:0];
          12'h034: m_lvl  = {10'd0, bus_wdata[5:0]};
          12'h038: m_mask = bus_wdata[10:0];
          12'h048: m_dma  = {13'd0, bus_wdata[2:0]};
          default: ;
        endcase
      end
      if (rx_valid) begin
        m_raw[4] = 1'b1;
        if (m_q.size() < DEPTH) m_q.push_back(rx_byte);
        else begin m_raw[10] = 1'b1; m_rsr[3] = 1'b1; end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (irq !== |(m_raw & m_mask)) begin
        errors++;
        $display("FAIL R8 irq actual=%0b expected=%0b", irq, |(m_raw & m_mask));
      end
      checks++;
      if (tx_valid !== e_txv) begin
        errors++;
        $display("FAIL R7 tx_valid actual=%0b expected=%0b", tx_valid, e_txv);
      end
      if (e_txv) begin
        checks++;
        if (tx_byte !== e_txb) begin
          errors++;
          $display("FAIL R7 tx_byte actual=%h expected=%h", tx_byte, e_txb);
        end
      end
      if (e_rd) begin
        checks++;
        if (bus_rdata !== e_rdata) begin
          errors++;
          $display("FAIL %s model read actual=%h expected=%h", e_tag, bus_rdata, e_rdata);
        end
      end
    end
  end

  task automatic cyc(bit rd, bit wr, logic [11:0] a, logic [31:0] d,
                     bit rv, logic [7:0] rb, string tag);
    @(posedge clk);
    #1;
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
    rx_valid = rv; rx_byte = rb; cur_tag = tag;
  endtask

  task automatic idle();
    cyc(0, 0, 12'h0, 32'h0, 0, 8'h0, cur_tag);
  endtask

  task automatic lit(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd_lit(logic [11:0] a, logic [31:0] exp, string tag);
    cyc(1, 0, a, 32'h0, 0, 8'h0, tag);
    idle();
    @(negedge clk);
    lit(tag, bus_rdata, exp);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, string tag);
    cyc(0, 1, a, d, 0, 8'h0, tag);
    idle();
  endtask

  task automatic push(logic [7:0] b, string tag);
    cyc(0, 0, 12'h0, 32'h0, 1, b, tag);
    idle();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    logic [7:0] ids [8];
    ids = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    idle();

    // R1 reset state
    rd_lit(12'h018, 32'h90, "R1");
    rd_lit(12'h03C, 32'h0, "R1");
    rd_lit(12'h038, 32'h0, "R1");
    rd_lit(12'h004, 32'h0, "R1");
    rd_lit(12'h024, 32'h0, "R1");
    lit("R1", {31'd0, irq}, 32'h0);

    // R10 storage widths
    wr(12'h020, 32'hFFFFFFFF, "R10"); rd_lit(12'h020, 32'hFF, "R10");
    wr(12'h024, 32'hFFFFFFFF, "R10"); rd_lit(12'h024, 32'hFFFF, "R10");
    wr(12'h028, 32'hFFFFFFFF, "R10"); rd_lit(12'h028, 32'h3F, "R10");
    wr(12'h02C, 32'h0000A5C3, "R10"); rd_lit(12'h02C, 32'hC3, "R10");
    wr(12'h030, 32'h12345678, "R10"); rd_lit(12'h030, 32'h5678, "R10");
    wr(12'h034, 32'hFFFFFFFF, "R10"); rd_lit(12'h034, 32'h3F, "R10");
    wr(12'h048, 32'hFFFFFFFF, "R10"); rd_lit(12'h048, 32'h7, "R10");

    // R11 identification
    for (int k = 0; k < 8; k++) rd_lit(12'hFE0 + 12'(k * 4), 32'(ids[k]), "R11");

    // R12 unmapped and read-only
    rd_lit(12'h044, 32'h0, "R12");
    rd_lit(12'h100, 32'h0, "R12");
    rd_lit(12'h008, 32'h0, "R12");
    wr(12'h018, 32'hFFFF, "R12"); rd_lit(12'h018, 32'h90, "R12");
    wr(12'h03C, 32'h7FF, "R12"); rd_lit(12'h03C, 32'h0, "R12");
    wr(12'h040, 32'h7FF, "R12"); rd_lit(12'h03C, 32'h0, "R12");
    wr(12'h200, 32'hFFFF, "R12"); rd_lit(12'h024, 32'hFFFF, "R12");

    // R3 / R2 / R4 receive path
    push(8'hA1, "R3"); push(8'hB2, "R3"); push(8'hC3, "R3");
    rd_lit(12'h018, 32'h80, "R3");
    rd_lit(12'h03C, 32'h10, "R3");
    rd_lit(12'h000, 32'hA1, "R2");
    rd_lit(12'h000, 32'hB2, "R2");
    rd_lit(12'h000, 32'hC3, "R2");
    rd_lit(12'h03C, 32'h0, "R4");
    rd_lit(12'h018, 32'h90, "R4");
    rd_lit(12'h000, 32'h0, "R2");

    // R8 mask and interrupt
    wr(12'h038, 32'hFFFF, "R8"); rd_lit(12'h038, 32'h7FF, "R8");
    wr(12'h038, 32'h10, "R8");
    push(8'h42, "R8");
    @(negedge clk); lit("R8", {31'd0, irq}, 32'h1);
    rd_lit(12'h040, 32'h10, "R8");
    // R4 last pop with simultaneous push
    cyc(1, 0, 12'h000, 32'h0, 1, 8'h55, "R4");
    idle();
    @(negedge clk); lit("R4", bus_rdata, 32'h42);
    rd_lit(12'h03C, 32'h10, "R4");
    rd_lit(12'h000, 32'h55, "R4");
    @(negedge clk); lit("R4", {31'd0, irq}, 32'h0);

    // R7 transmit
    cyc(0, 1, 12'h000, 32'h00001234, 0, 8'h0, "R7");
    idle();
    @(negedge clk);
    lit("R7", {31'd0, tx_valid}, 32'h1);
    lit("R7", {24'd0, tx_byte}, 32'h34);
    idle();
    @(negedge clk);
    lit("R7", {31'd0, tx_valid}, 32'h0);
    rd_lit(12'h03C, 32'h20, "R7");
    rd_lit(12'h018, 32'h90, "R7");

    // R9 clear, and set winning over clear
    wr(12'h044, 32'h20, "R9"); rd_lit(12'h03C, 32'h0, "R9");
    cyc(0, 1, 12'h044, 32'h10, 1, 8'h66, "R9");
    idle();
    rd_lit(12'h03C, 32'h10, "R9");
    rd_lit(12'h000, 32'h66, "R9");

    // R5 / R6 full queue and overrun
    for (int i = 1; i <= DEPTH; i++) cyc(0, 0, 12'h0, 32'h0, 1, 8'(i), "R5");
    idle();
    rd_lit(12'h018, 32'hC0, "R5");
    push(8'hEE, "R6");
    rd_lit(12'h004, 32'h8, "R6");
    rd_lit(12'h03C, 32'h410, "R6");
    wr(12'h044, 32'h400, "R6");
    cyc(1, 0, 12'h000, 32'h0, 1, 8'h77, "R5");
    idle();
    @(negedge clk); lit("R5", bus_rdata, 32'h01);
    rd_lit(12'h03C, 32'h010, "R5");
    rd_lit(12'h018, 32'hC0, "R5");
    wr(12'h004, 32'h0, "R6");
    rd_lit(12'h004, 32'h0, "R6");
    for (int i = 2; i <= DEPTH; i++) rd_lit(12'h000, 32'(i), "R5");
    rd_lit(12'h000, 32'h77, "R5");
    rd_lit(12'h018, 32'h90, "R5");

    repeat (3) idle();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule